// File: doc/BRIEF.md
# Power-Up and Reset Sequencer with Non-Volatile Default Load

This block brings a configurable clock device out of power-up or reset in a fixed order. It first copies one default word per configuration register from a small read-only store into the live register file, fetching over a valid/ready read port. It then waits out a fixed settling phase. Only after that does it open the host register port and enable the clock outputs.

Two reset classes exist. A hard reset comes from an active-low pin, which is synchronized inside the block, or from a self-clearing control bit. It clears all state, including the host-side control bits, and repeats the full default load. A soft reset, also a self-clearing control bit, skips the load and re-runs only the settling phase. Values the host has written therefore survive a soft reset and take effect.

The host reaches the config registers at addresses 0 to NREG-1. The control register sits at address NREG. In that register, bit 0 requests a hard reset and bit 1 requests a soft reset.

Top module: `seqctl_top`

## Requirements
- R1: After power-on the block reads store entries 0 through NREG-1 in ascending order, one per accepted read (valid and ready both high at a clock edge). Once ready, a host read of config address i returns the store word for entry i.
- R2: While the store holds ready low, the read address and valid stay unchanged. Each entry is fetched exactly once per load.
- R3: While not ready, `host_ready` is low and `busy` is high. Host reads return zero and host writes are dropped. When ready, `busy` is low and writes to config addresses read back.
- R4: `clk_out_en` is low from reset until the ready state and high while in it.
- R5: The settling phase lasts INIT_CYCLES clock edges. `host_ready` rises on the INIT_CYCLES-th edge after the edge that accepted the last store word.
- R6: Writing 1 to bit 0 of the control register (address NREG) starts a hard reset. The full load repeats and every config register returns to its store word.
- R7: Writing 1 to bit 1 of the control register starts a soft reset. No store reads take place, host-written values are kept, and `host_ready` rises INIT_CYCLES+1 edges after the edge that took the write.
- R8: If bits 0 and 1 are written together, the hard reset is performed.
- R9: Control bits clear themselves one cycle after the write. A single soft-reset write gives exactly one settling pass, after which the block stays ready.
- R10: The reset pin passes through two flops. A low pin forces the reset state on the third edge after it falls. No store reads happen while it is low. The load starts (valid high) after the third edge following its release.
- R11: A pin reset during a load abandons it. The next load restarts at entry 0 and fetches all NREG entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| rst_pin_n | input | 1 | Asynchronous hard-reset pin, active low |
| host_we | input | 1 | Host register write strobe |
| host_re | input | 1 | Host register read strobe |
| host_addr | input | AW | Host register address (NREG = control) |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data, zero unless ready |
| host_ready | output | 1 | Host interface open |
| busy | output | 1 | Load or settling in progress |
| clk_out_en | output | 1 | Clock output enable |
| nvm_rd_valid | output | 1 | Store read request valid |
| nvm_rd_addr | output | NVM_AW | Store entry index |
| nvm_rd_ready | input | 1 | Store accepts the read this cycle |
| nvm_rd_data | input | DW | Store word for `nvm_rd_addr` |

## Verification
The hardest case to reach is a pin reset that lands partway through a store load that is itself being stalled. If the restart does not return to entry 0, the fault shows only as a wrong register value later. The stimulus first starts a load with the hard-reset control bit and lets the store stall on every third cycle. It then pulls the pin low once a few entries have been accepted, and after release it checks that the logged fetch sequence begins again at 0. Cycle counts between the last accepted fetch, or the control write, and the rise of `host_ready` pin down the settling length and the two-flop pin delay.

// File: rtl/seqctl_pkg.sv
// Shared types for the reset/load sequencer.
// Assumes: nothing beyond a single clock domain.
package seqctl_pkg;
    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_LOAD  = 2'd1,
        ST_INIT  = 2'd2,
        ST_READY = 2'd3
    } seq_state_t;
endpackage

// File: rtl/seqctl_pin_sync.sv
// Two-flop synchronizer for the asynchronous active-low reset pin.
// Assumes: output reads as asserted (0) while power-on reset is held,
// so release always costs two clock edges.
module seqctl_pin_sync (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n,
    output logic pin_ok
);
    logic stage1;

    // Shift the pin level through two flops.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            stage1 <= 1'b0;
            pin_ok <= 1'b0;
        end else begin
            stage1 <= pin_n;
            pin_ok <= stage1;
        end
    end
endmodule

// File: rtl/seqctl_fsm.sv
// Sequencer state machine: RESET -> LOAD -> INIT -> READY.
// LOAD steps one store entry per accepted read; INIT waits INIT_CYCLES edges.
// Assumes: INIT_CYCLES >= 1, NREG >= 2, control bits only arrive in READY.
module seqctl_fsm
    import seqctl_pkg::*;
#(
    parameter int NREG        = 8,
    parameter int INIT_CYCLES = 16,
    parameter int IW          = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          pin_ok,
    input  logic          ctrl_hard,
    input  logic          ctrl_soft,
    input  logic          nvm_ready,
    output seq_state_t    state,
    output logic          nvm_valid,
    output logic          load_fire,
    output logic [IW-1:0] load_idx
);
    localparam int CW = $clog2(INIT_CYCLES + 1);
    localparam logic [IW-1:0] LAST_IDX  = IW'(NREG - 1);
    localparam logic [CW-1:0] LAST_WAIT = CW'(INIT_CYCLES - 1);

    logic [CW-1:0] wait_cnt;

    // Read request and accept strobe toward the store.
    always_comb begin
        nvm_valid = (state == ST_LOAD);
        load_fire = nvm_valid && nvm_ready;
    end

    // State, entry index and settle counter.
    always_ff @(posedge clk) begin
        if (!por_n || !pin_ok) begin
            state    <= ST_RESET;
            load_idx <= '0;
            wait_cnt <= '0;
        end else begin
            case (state)
                ST_RESET: begin
                    state    <= ST_LOAD;
                    load_idx <= '0;
                end
                ST_LOAD: begin
                    if (load_fire) begin
                        if (load_idx == LAST_IDX) begin
                            state    <= ST_INIT;
                            wait_cnt <= '0;
                        end else begin
                            load_idx <= load_idx + 1'b1;
                        end
                    end
                end
                ST_INIT: begin
                    if (wait_cnt == LAST_WAIT) state <= ST_READY;
                    else                       wait_cnt <= wait_cnt + 1'b1;
                end
                default: begin
                    if (ctrl_hard) begin
                        state <= ST_RESET;
                    end else if (ctrl_soft) begin
                        state    <= ST_INIT;
                        wait_cnt <= '0;
                    end
                end
            endcase
        end
    end

    // R2: a stalled read keeps its index and stays in LOAD.
    a_r2_stall_hold: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_LOAD && !nvm_ready && pin_ok) |=> (state == ST_LOAD && $stable(load_idx)));

    // R2: each accepted read below the last advances the index by one.
    a_r2_step_one: assert property (@(posedge clk) disable iff (!por_n)
        (load_fire && load_idx != LAST_IDX && pin_ok) |=> (load_idx == $past(load_idx) + 1'b1));

    // R8: hard request in READY always goes to RESET, soft or not.
    a_r8_hard_wins: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_READY && ctrl_hard && pin_ok) |=> (state == ST_RESET));

    // R7: soft-only request re-enters INIT without a load.
    a_r7_soft_to_init: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_READY && ctrl_soft && !ctrl_hard && pin_ok) |=> (state == ST_INIT));

    // R10: a synchronized low pin forces RESET on the next edge.
    a_r10_pin_forces_reset: assert property (@(posedge clk) disable iff (!por_n)
        !pin_ok |=> (state == ST_RESET));
endmodule

// File: rtl/seqctl_regfile.sv
// Live configuration registers plus the self-clearing reset-request bits.
// Loaded from the store during LOAD; host access only while host_en is high.
// Assumes: control register sits at address NREG, bit0 hard, bit1 soft.
module seqctl_regfile #(
    parameter int NREG = 8,
    parameter int DW   = 8,
    parameter int AW   = $clog2(NREG + 1),
    parameter int IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          clear,
    input  logic          load_fire,
    input  logic [IW-1:0] load_idx,
    input  logic [DW-1:0] load_data,
    input  logic          host_en,
    input  logic          host_we,
    input  logic          host_re,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] rd_data,
    output logic          ctrl_hard,
    output logic          ctrl_soft
);
    localparam logic [AW-1:0] CTRL_ADDR = AW'(NREG);

    logic [DW-1:0] regs [NREG];
    logic          wr_ok;

    // Host writes are accepted only while the interface is open.
    assign wr_ok = host_en && host_we;

    // Register storage: cleared in RESET, filled by the load, then host-written.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!por_n || clear)
                regs[i] <= '0;
            else if (load_fire && load_idx == IW'(i))
                regs[i] <= load_data;
            else if (wr_ok && host_addr == AW'(i))
                regs[i] <= host_wdata;
        end
    end

    // Reset-request bits live for exactly one cycle after the write.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            ctrl_hard <= 1'b0;
            ctrl_soft <= 1'b0;
        end else if (wr_ok && host_addr == CTRL_ADDR) begin
            ctrl_hard <= host_wdata[0];
            ctrl_soft <= host_wdata[1];
        end else begin
            ctrl_hard <= 1'b0;
            ctrl_soft <= 1'b0;
        end
    end

    // Read mux: zero unless open and the address names a config register.
    always_comb begin
        rd_data = '0;
        if (host_en && host_re) begin
            for (int i = 0; i < NREG; i++) begin
                if (host_addr == AW'(i)) rd_data = regs[i];
            end
        end
    end

    // R9: the soft bit never survives two cycles.
    a_r9_soft_selfclear: assert property (@(posedge clk) disable iff (!por_n)
        ctrl_soft |=> !ctrl_soft);

    // R9: the hard bit never survives two cycles.
    a_r9_hard_selfclear: assert property (@(posedge clk) disable iff (!por_n)
        ctrl_hard |=> !ctrl_hard);
endmodule

// File: rtl/seqctl_top.sv
// Top of the power-up/reset sequencer: pin synchronizer, state machine and
// register file. Host port and clock enable open only in READY.
// Assumes: the store answers combinationally for the presented index.
module seqctl_top
    import seqctl_pkg::*;
#(
    parameter int NREG        = 8,
    parameter int DW          = 8,
    parameter int INIT_CYCLES = 16,
    parameter int AW          = $clog2(NREG + 1),
    parameter int NVM_AW      = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_pin_n,
    input  logic              host_we,
    input  logic              host_re,
    input  logic [AW-1:0]     host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    output logic              host_ready,
    output logic              busy,
    output logic              clk_out_en,
    output logic              nvm_rd_valid,
    output logic [NVM_AW-1:0] nvm_rd_addr,
    input  logic              nvm_rd_ready,
    input  logic [DW-1:0]     nvm_rd_data
);
    seq_state_t state;
    logic       pin_ok;
    logic       ctrl_hard;
    logic       ctrl_soft;
    logic       load_fire;

    seqctl_pin_sync u_sync (
        .clk    (clk),
        .por_n  (por_n),
        .pin_n  (rst_pin_n),
        .pin_ok (pin_ok)
    );

    seqctl_fsm #(
        .NREG        (NREG),
        .INIT_CYCLES (INIT_CYCLES),
        .IW          (NVM_AW)
    ) u_fsm (
        .clk       (clk),
        .por_n     (por_n),
        .pin_ok    (pin_ok),
        .ctrl_hard (ctrl_hard),
        .ctrl_soft (ctrl_soft),
        .nvm_ready (nvm_rd_ready),
        .state     (state),
        .nvm_valid (nvm_rd_valid),
        .load_fire (load_fire),
        .load_idx  (nvm_rd_addr)
    );

    seqctl_regfile #(
        .NREG (NREG),
        .DW   (DW),
        .AW   (AW),
        .IW   (NVM_AW)
    ) u_regs (
        .clk        (clk),
        .por_n      (por_n),
        .clear      (state == ST_RESET),
        .load_fire  (load_fire),
        .load_idx   (nvm_rd_addr),
        .load_data  (nvm_rd_data),
        .host_en    (host_ready),
        .host_we    (host_we),
        .host_re    (host_re),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .rd_data    (host_rdata),
        .ctrl_hard  (ctrl_hard),
        .ctrl_soft  (ctrl_soft)
    );

    // Status and gating outputs decoded from the sequencer state.
    always_comb begin
        host_ready = (state == ST_READY);
        busy       = !host_ready;
        clk_out_en = host_ready;
    end

    // R3: read data stays zero whenever the sequencer is busy.
    a_r3_rdata_zero_busy: assert property (@(posedge clk) disable iff (!por_n)
        busy |-> (host_rdata == '0));

    // R4: clocks are never enabled while a store read is pending.
    a_r4_no_clk_in_load: assert property (@(posedge clk) disable iff (!por_n)
        nvm_rd_valid |-> !clk_out_en);
endmodule

// File: tb/seqctl_top_tb_top.sv
`timescale 1ns/1ps
module seqctl_top_tb_top;
    localparam int NREG = 8;
    localparam int DW   = 8;
    localparam int INIT_CYCLES = 16;
    localparam int AW   = 4;
    localparam int NAW  = 3;
    localparam logic [AW-1:0] CTRL = AW'(NREG);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic           por_n = 1'b0;
    logic           rst_pin_n = 1'b1;
    logic           host_we = 1'b0;
    logic           host_re = 1'b0;
    logic [AW-1:0]  host_addr = '0;
    logic [DW-1:0]  host_wdata = '0;
    logic [DW-1:0]  host_rdata;
    logic           host_ready, busy, clk_out_en;
    logic           nvm_rd_valid;
    logic [NAW-1:0] nvm_rd_addr;
    logic           nvm_rd_ready = 1'b1;
    logic [DW-1:0]  nvm_rd_data;

    seqctl_top #(.NREG(NREG), .DW(DW), .INIT_CYCLES(INIT_CYCLES)) dut_i (
        .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n),
        .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ready(host_ready), .busy(busy), .clk_out_en(clk_out_en),
        .nvm_rd_valid(nvm_rd_valid), .nvm_rd_addr(nvm_rd_addr),
        .nvm_rd_ready(nvm_rd_ready), .nvm_rd_data(nvm_rd_data)
    );

    // Store model: word per entry, computed.
    function automatic logic [DW-1:0] nvm_word(int a);
        return DW'(a * 37 + 90);
    endfunction
    assign nvm_rd_data = nvm_word(int'(nvm_rd_addr));

    int total = 0;
    int bad   = 0;
    int ncyc  = 0;
    int acc_cnt = 0;
    int last_acc = 0;
    int acc_log [256];

    // Negedge: stall pattern on ready, log the read the next edge accepts.
    always @(negedge clk) begin
        ncyc++;
        nvm_rd_ready = (ncyc % 3 != 1);
        if (nvm_rd_valid && nvm_rd_ready) begin
            if (acc_cnt < 256) acc_log[acc_cnt] = int'(nvm_rd_addr);
            acc_cnt++;
            last_acc = ncyc;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                              output int at);
        @(negedge clk); #0.5;
        host_we = 1'b1; host_addr = a; host_wdata = d; at = ncyc;
        @(negedge clk); #0.5;
        host_we = 1'b0;
    endtask

    task automatic host_read(input logic [AW-1:0] a, output int d);
        @(negedge clk); #0.5;
        host_re = 1'b1; host_addr = a;
        #1;
        d = int'(host_rdata);
        @(negedge clk); #0.5;
        host_re = 1'b0;
    endtask

    task automatic wait_ready(output int at);
        at = -1;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk); #1;
            if (host_ready) begin at = ncyc; break; end
        end
    endtask

    task automatic check_all_regs(input string req);
        int d;
        for (int i = 0; i < NREG; i++) begin
            host_read(AW'(i), d);
            chk(d == int'(nvm_word(i)), req, "register matches store word", d, int'(nvm_word(i)));
        end
    endtask

    task automatic check_log(input int base, input string req);
        chk(acc_cnt - base == NREG, req, "store reads per load", acc_cnt - base, NREG);
        for (int i = 0; i < NREG; i++)
            chk(acc_log[base + i] == i, req, "ascending fetch order", acc_log[base + i], i);
    endtask

    // R3/R4: outputs while power-on reset is held.
    task automatic t_reset_state();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            chk(!host_ready, "R3", "ready low in reset", int'(host_ready), 0);
            chk(busy, "R3", "busy high in reset", int'(busy), 1);
            chk(!clk_out_en, "R4", "clock gated in reset", int'(clk_out_en), 0);
        end
    endtask

    // R1/R2/R3/R5: first load, write dropped while busy, settle length.
    task automatic t_power_on();
        int base, la, at, r, d;
        base = acc_cnt;
        @(negedge clk); #0.5; por_n = 1'b1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk); #1;
            if (acc_cnt >= base + NREG) break;
        end
        la = last_acc;
        check_log(base, "R2");
        host_write(AW'(2), 8'hEE, at);
        host_read(AW'(2), d);
        chk(d == 0, "R3", "read while busy is zero", d, 0);
        chk(busy, "R3", "busy during settle", int'(busy), 1);
        chk(!clk_out_en, "R4", "clock gated during settle", int'(clk_out_en), 0);
        wait_ready(r);
        chk(r - la == INIT_CYCLES + 1, "R5", "settle length after last fetch", r - la, INIT_CYCLES + 1);
        chk(clk_out_en, "R4", "clock enabled when ready", int'(clk_out_en), 1);
        chk(!busy, "R3", "busy low when ready", int'(busy), 0);
        check_all_regs("R1");
    endtask

    // R3: host write/read in ready; control write of zero does nothing.
    task automatic t_write_read();
        int at, d;
        host_write(AW'(5), 8'h3C, at);
        host_read(AW'(5), d);
        chk(d == 8'h3C, "R3", "write readback in ready", d, 8'h3C);
        host_write(CTRL, 8'h00, at);
        repeat (3) @(negedge clk);
        #1;
        chk(host_ready, "R9", "zero control write keeps ready", int'(host_ready), 1);
    endtask

    // R7/R9: soft reset keeps values, no store reads, one pass only.
    task automatic t_soft();
        int at, r, d, base;
        host_write(AW'(4), 8'hA7, at);
        base = acc_cnt;
        host_write(CTRL, 8'h02, at);
        @(negedge clk); #1;
        chk(busy, "R7", "busy after soft reset", int'(busy), 1);
        wait_ready(r);
        chk(r - at == INIT_CYCLES + 2, "R7", "soft settle timing", r - at, INIT_CYCLES + 2);
        chk(acc_cnt == base, "R7", "no store reads on soft reset", acc_cnt - base, 0);
        host_read(AW'(4), d);
        chk(d == 8'hA7, "R7", "host value kept over soft reset", d, 8'hA7);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk); #1;
            if (!host_ready) begin
                chk(0, "R9", "ready stays after single soft pass", 0, 1);
                break;
            end
        end
        chk(host_ready, "R9", "ready after 30 cycles", int'(host_ready), 1);
    endtask

    // R6: control hard reset reloads everything.
    task automatic t_hard_bit();
        int at, r, d, base;
        host_write(AW'(3), 8'h5A, at);
        host_read(AW'(3), d);
        chk(d == 8'h5A, "R6", "pre-reset write", d, 8'h5A);
        base = acc_cnt;
        host_write(CTRL, 8'h01, at);
        wait_ready(r);
        chk(r > 0, "R6", "ready returns after hard bit", r, 1);
        check_log(base, "R6");
        check_all_regs("R6");
    endtask

    // R8: both bits at once behave as hard reset.
    task automatic t_both();
        int at, r, d, base;
        host_write(AW'(6), 8'h11, at);
        base = acc_cnt;
        host_write(CTRL, 8'h03, at);
        wait_ready(r);
        chk(acc_cnt - base == NREG, "R8", "both bits reload store", acc_cnt - base, NREG);
        host_read(AW'(6), d);
        chk(d == int'(nvm_word(6)), "R8", "host value replaced", d, int'(nvm_word(6)));
    endtask

    // R10: pin reset from ready, synchronizer latency on entry and release.
    task automatic t_pin_ready();
        int base, r;
        @(negedge clk); #0.5; rst_pin_n = 1'b0;
        @(negedge clk); #1;
        chk(host_ready, "R10", "ready one edge after pin low", int'(host_ready), 1);
        @(negedge clk); #1;
        chk(host_ready, "R10", "ready two edges after pin low", int'(host_ready), 1);
        @(negedge clk); #1;
        chk(!host_ready, "R10", "reset on third edge", int'(host_ready), 0);
        base = acc_cnt;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); #1;
            if (nvm_rd_valid) begin
                chk(0, "R10", "no store read while pin low", 1, 0);
                break;
            end
        end
        chk(acc_cnt == base, "R10", "no fetches while pin low", acc_cnt - base, 0);
        @(negedge clk); #0.5; rst_pin_n = 1'b1;
        @(negedge clk); #1;
        @(negedge clk); #1;
        chk(!nvm_rd_valid, "R10", "load not started two edges after release", int'(nvm_rd_valid), 0);
        @(negedge clk); #1;
        chk(nvm_rd_valid, "R10", "load starts third edge after release", int'(nvm_rd_valid), 1);
        wait_ready(r);
        check_log(base, "R10");
    endtask

    // R11: pin reset during a stalled load restarts from entry 0.
    task automatic t_pin_load();
        int at, r, base, base2;
        base = acc_cnt;
        host_write(CTRL, 8'h01, at);
        for (int k = 0; k < 100; k++) begin
            @(negedge clk); #1;
            if (acc_cnt >= base + 3) break;
        end
        #0.5; rst_pin_n = 1'b0;
        repeat (5) @(negedge clk);
        #1;
        base2 = acc_cnt;
        chk(!nvm_rd_valid, "R11", "load abandoned", int'(nvm_rd_valid), 0);
        @(negedge clk); #0.5; rst_pin_n = 1'b1;
        wait_ready(r);
        check_log(base2, "R11");
        check_all_regs("R11");
    endtask

    initial begin
        t_reset_state();
        t_power_on();
        t_write_read();
        t_soft();
        t_hard_bit();
        t_both();
        t_pin_ready();
        t_pin_load();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule